// File: doc/BRIEF.md
# Conversion Interrupt Flag and Vector Unit

This block collects the interrupt conditions of a multi-slot conversion engine and presents them to software as one request line and one prioritised, even-valued vector. Each of the result slots has a ready flag that a result write sets and a result read clears. Two error conditions are also caught. The overwrite error fires when a slot that still holds an unread result is written again. The late-request error fires when a new sample request arrives while a conversion is still running.

Software reads the vector and adds it to its program counter to reach the matching handler. A vector of zero means nothing is pending. Reading the vector acknowledges either error condition when that condition is the value returned. Slot flags are cleared only by reading the slot's result.

Top module: `cvt_irq_ctrl`

## Requirements
- R1: After reset every flag is clear, `vec` is 0 and `irq` is 0.
- R2: A `wr_stb` for slot n sets that slot's flag on the next cycle. With `slot_en[n]` set and no higher source pending, `vec` then reads 6+2n.
- R3: `irq` is high exactly when `gie` is high and `vec` is nonzero. With `gie` low, `vec` still reports the pending source.
- R4: A write to a slot whose previous result is still unread sets the overwrite flag. While `ovf_en` is set, that flag is reported as `vec` = 2.
- R5: `req_stb` while `busy` is high sets the late-request flag, reported as `vec` = 4 while `tov_en` is set. `req_stb` without `busy`, or `busy` without `req_stb`, sets nothing.
- R6: Priority runs from highest to lowest as: overwrite (2), late-request (4), then slot 0 through slot 15 (6+2n). `vec` is always even.
- R7: A `rd_stb` for slot n clears that slot's flag and its unread marker. A later single write to slot n therefore does not set the overwrite flag.
- R8: A `vec_rd` while `vec` is 2 clears the overwrite flag. A `vec_rd` while `vec` is 4 clears the late-request flag. A `vec_rd` while `vec` shows a slot value changes no flag.
- R9: A source whose enable bit is low is left out of `vec` and `irq`, but its flag stays latched. Setting the enable later makes the source appear.
- R10: A write and a read of the same slot in the same cycle leave that slot's flag set and do not set the overwrite flag.
- R11: When a condition's set and its `vec_rd` clear happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Result written into a slot |
| wr_slot | input | 4 | Slot index of the write |
| rd_stb | input | 1 | Result read from a slot |
| rd_slot | input | 4 | Slot index of the read |
| req_stb | input | 1 | Sample-and-convert request |
| busy | input | 1 | Conversion in progress |
| slot_en | input | 16 | Per-slot interrupt enables |
| ovf_en | input | 1 | Overwrite-error enable |
| tov_en | input | 1 | Late-request-error enable |
| gie | input | 1 | Global interrupt enable |
| vec_rd | input | 1 | Software read of the vector |
| irq | output | 1 | Interrupt request |
| vec | output | 6 | Prioritised even vector |

## Verification
The assertions check these properties on every cycle: a write sets its slot's flag, a read clears it, an overwrite or a request while busy raises its error flag one cycle later, an acknowledge clears the error that was returned, the vector is always even, and an enabled error under global enable raises the request. The relative priority among several pending sources, the masking-then-unmasking of latched flags, the same-cycle write and read of one slot, and the set-beats-acknowledge collision only show up in the bench's ordered scenarios, which compare the vector against values worked out from the requirements.

// File: rtl/cvt_irq_pkg.sv
package cvt_irq_pkg;
    localparam int VEC_NONE      = 0;
    localparam int VEC_OVF       = 2;
    localparam int VEC_TOV       = 4;
    localparam int VEC_SLOT_BASE = 6;

    typedef struct packed {
        logic ovf;
        logic tov;
    } err_state_t;
endpackage

// File: rtl/cvt_slot_flags.sv
module cvt_slot_flags #(
    parameter int NUM_SLOTS = 16,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  logic [SLOT_W-1:0]    wr_slot,
    input  logic                 rd_stb,
    input  logic [SLOT_W-1:0]    rd_slot,
    output logic [NUM_SLOTS-1:0] flags,
    output logic                 overwrite
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] flag;
        logic [NUM_SLOTS-1:0] unread;
    } slot_state_t;

    slot_state_t st_d, st_q;
    logic same_slot;

    always_comb begin
        st_d      = st_q;
        same_slot = rd_stb && wr_stb && (rd_slot == wr_slot);
        // an unread result is overwritten unless it is read in this same cycle
        overwrite = wr_stb && st_q.unread[wr_slot] && !same_slot;
        if (rd_stb) begin
            st_d.flag[rd_slot]   = 1'b0;
            st_d.unread[rd_slot] = 1'b0;
        end
        if (wr_stb) begin
            st_d.flag[wr_slot]   = 1'b1;
            st_d.unread[wr_slot] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flag;

    assert_slot_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> flags[$past(wr_slot)]);

    assert_slot_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !(wr_stb && wr_slot == rd_slot)) |=> !flags[$past(rd_slot)]);

    assert_same_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && wr_stb && wr_slot == rd_slot) |-> !overwrite);
endmodule

// File: rtl/cvt_vec_encode.sv
module cvt_vec_encode
    import cvt_irq_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    localparam int VEC_W = $clog2(2 * NUM_SLOTS + 5)
) (
    input  logic [NUM_SLOTS-1:0] flags,
    input  logic [NUM_SLOTS-1:0] slot_en,
    input  logic                 ovf,
    input  logic                 ovf_en,
    input  logic                 tov,
    input  logic                 tov_en,
    output logic [VEC_W-1:0]     vec
);
    always_comb begin
        vec = VEC_W'(VEC_NONE);
        // walk from the lowest priority upward so the last hit wins
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (flags[i] && slot_en[i]) vec = VEC_W'(VEC_SLOT_BASE + 2 * i);
        end
        if (tov && tov_en) vec = VEC_W'(VEC_TOV);
        if (ovf && ovf_en) vec = VEC_W'(VEC_OVF);
    end
endmodule

// File: rtl/cvt_irq_ctrl.sv
module cvt_irq_ctrl
    import cvt_irq_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int VEC_W  = $clog2(2 * NUM_SLOTS + 5)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  logic [SLOT_W-1:0]    wr_slot,
    input  logic                 rd_stb,
    input  logic [SLOT_W-1:0]    rd_slot,
    input  logic                 req_stb,
    input  logic                 busy,
    input  logic [NUM_SLOTS-1:0] slot_en,
    input  logic                 ovf_en,
    input  logic                 tov_en,
    input  logic                 gie,
    input  logic                 vec_rd,
    output logic                 irq,
    output logic [VEC_W-1:0]     vec
);
    logic [NUM_SLOTS-1:0] flags;
    logic                 overwrite;
    err_state_t           err_d, err_q;

    cvt_slot_flags #(.NUM_SLOTS(NUM_SLOTS)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_slot   (wr_slot),
        .rd_stb    (rd_stb),
        .rd_slot   (rd_slot),
        .flags     (flags),
        .overwrite (overwrite)
    );

    cvt_vec_encode #(.NUM_SLOTS(NUM_SLOTS)) u_enc (
        .flags   (flags),
        .slot_en (slot_en),
        .ovf     (err_q.ovf),
        .ovf_en  (ovf_en),
        .tov     (err_q.tov),
        .tov_en  (tov_en),
        .vec     (vec)
    );

    always_comb begin
        err_d = err_q;
        // acknowledge first, so a same-cycle set takes precedence
        if (vec_rd && vec == VEC_W'(VEC_OVF)) err_d.ovf = 1'b0;
        if (vec_rd && vec == VEC_W'(VEC_TOV)) err_d.tov = 1'b0;
        if (overwrite)       err_d.ovf = 1'b1;
        if (req_stb && busy) err_d.tov = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign irq = gie && (vec != VEC_W'(VEC_NONE));

    assert_ovf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        overwrite |=> err_q.ovf);

    assert_tov_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_stb && busy) |=> err_q.tov);

    assert_vec_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec[0] == 1'b0);

    assert_err_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gie && ovf_en && err_q.ovf) |-> irq);

    assert_ovf_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && vec == VEC_W'(VEC_OVF) && !overwrite) |=> !err_q.ovf);
endmodule

// File: tb/cvt_irq_ctrl_tb.sv
module cvt_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0, rd_stb = 1'b0, req_stb = 1'b0, busy = 1'b0, vec_rd = 1'b0;
    logic [3:0]  wr_slot = '0, rd_slot = '0;
    logic [15:0] slot_en = '0;
    logic        ovf_en = 1'b0, tov_en = 1'b0, gie = 1'b0;
    logic        irq;
    logic [5:0]  vec;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cvt_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_slot(wr_slot),
        .rd_stb(rd_stb), .rd_slot(rd_slot), .req_stb(req_stb), .busy(busy),
        .slot_en(slot_en), .ovf_en(ovf_en), .tov_en(tov_en), .gie(gie),
        .vec_rd(vec_rd), .irq(irq), .vec(vec)
    );

    typedef struct packed {
        logic       wr;
        logic [3:0] ws;
        logic       rd;
        logic [3:0] rs;
        logic       req;
        logic       bsy;
        logic       vrd;
        logic [5:0] ev;
        logic       ei;
        logic [3:0] rq;
    } row_t;

    localparam int NROWS = 15;
    localparam row_t TBL [NROWS] = '{
        '{1'b1, 4'd3,  1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 6'd12, 1'b1, 4'd2},  // R2 write slot 3
        '{1'b1, 4'd1,  1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 6'd8,  1'b1, 4'd6},  // R6 slot 1 beats slot 3
        '{1'b0, 4'd0,  1'b1, 4'd1,  1'b0, 1'b0, 1'b0, 6'd12, 1'b1, 4'd7},  // R7 read slot 1
        '{1'b1, 4'd3,  1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 6'd2,  1'b1, 4'd4},  // R4 overwrite slot 3
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 1'b1, 1'b0, 6'd2,  1'b1, 4'd6},  // R6 overwrite above late req
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 6'd4,  1'b1, 4'd8},  // R8 ack overwrite
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 6'd12, 1'b1, 4'd8},  // R8 ack late req
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 6'd12, 1'b1, 4'd8},  // R8 ack on slot value no effect
        '{1'b0, 4'd0,  1'b1, 4'd3,  1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 4'd7},  // R7 read slot 3
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 6'd0,  1'b0, 4'd5},  // R5 request while idle
        '{1'b1, 4'd15, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 6'd36, 1'b1, 4'd2},  // R2 highest slot
        '{1'b1, 4'd15, 1'b1, 4'd15, 1'b0, 1'b0, 1'b0, 6'd36, 1'b1, 4'd10}, // R10 write+read same slot
        '{1'b0, 4'd0,  1'b1, 4'd15, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 4'd10}, // R10 flag stayed, no ovf
        '{1'b1, 4'd1,  1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 6'd8,  1'b1, 4'd7},  // R7 unread cleared earlier
        '{1'b0, 4'd0,  1'b1, 4'd1,  1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 4'd7}   // R7 read slot 1
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [3:0] ws, input logic rd,
                        input logic [3:0] rs, input logic rq, input logic bs,
                        input logic vr);
        wr_stb = wr; wr_slot = ws; rd_stb = rd; rd_slot = rs;
        req_stb = rq; busy = bs; vec_rd = vr;
        @(posedge clk);
        #1;
        wr_stb = 1'b0; rd_stb = 1'b0; req_stb = 1'b0; busy = 1'b0; vec_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        slot_en = '1; ovf_en = 1'b1; tov_en = 1'b1; gie = 1'b1;
        #1;
        check("R1 vec", int'(vec), 0);   // R1
        check("R1 irq", int'(irq), 0);

        for (int i = 0; i < NROWS; i++) begin
            step(TBL[i].wr, TBL[i].ws, TBL[i].rd, TBL[i].rs, TBL[i].req, TBL[i].bsy, TBL[i].vrd);
            check($sformatf("R%0d vec row %0d", TBL[i].rq, i), int'(vec), int'(TBL[i].ev));
            check($sformatf("R%0d irq row %0d", TBL[i].rq, i), int'(irq), int'(TBL[i].ei));
        end

        // R3: global enable off masks irq but not vec
        gie = 1'b0;
        step(1'b1, 4'd2, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
        check("R3 vec gie off", int'(vec), 10);
        check("R3 irq gie off", int'(irq), 0);
        gie = 1'b1; #1;
        check("R3 irq gie on", int'(irq), 1);
        step(1'b0, 4'd0, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0);

        // R9: disabled slot stays latched
        slot_en[5] = 1'b0;
        step(1'b1, 4'd5, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
        check("R9 masked slot vec", int'(vec), 0);
        check("R9 masked slot irq", int'(irq), 0);
        slot_en[5] = 1'b1; #1;
        check("R9 unmasked slot vec", int'(vec), 16);
        step(1'b0, 4'd0, 1'b1, 4'd5, 1'b0, 1'b0, 1'b0);

        // R9: disabled overwrite error stays latched
        ovf_en = 1'b0;
        step(1'b1, 4'd4, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 4'd4, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
        check("R9 masked ovf vec", int'(vec), 14);
        ovf_en = 1'b1; #1;
        check("R9 unmasked ovf vec", int'(vec), 2);
        step(1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1);
        check("R8 ovf ack vec", int'(vec), 14);
        step(1'b0, 4'd0, 1'b1, 4'd4, 1'b0, 1'b0, 1'b0);
        check("R7 clean after read", int'(vec), 0);

        // R11: set wins over acknowledge in same cycle
        step(1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0);
        check("R5 late req vec", int'(vec), 4);
        step(1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b1);
        check("R11 set beats ack", int'(vec), 4);
        step(1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1);
        check("R8 tov ack", int'(vec), 0);

        // R5: busy alone sets nothing
        step(1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0);
        check("R5 busy alone", int'(vec), 0);

        // R1: reset clears latched state
        step(1'b1, 4'd7, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0);
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1; #1;
        check("R1 vec after reset", int'(vec), 0);
        check("R1 irq after reset", int'(irq), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule